// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs processor-side memory and I/O transfers over a narrow time-shared bus. The low byte carries the address in the first bus state and data afterwards. The top nibble carries the high address bits first and then a status word. The upper address byte is driven steadily for the whole transfer. A client presents a request with a 20-bit address, a read/write flag, a memory/I/O flag, a two-bit segment tag and write data. The sequencer steps through T1, T2, T3, as many wait states as the ready input demands, and T4.

During a read, the low byte is released after T1 and the active-low read strobe is asserted. The byte on the bus is captured just before T4. An external master may ask for the bus. The grant comes only between transfers, and while it stands the sequencer floats its outputs. Each pin group that can float has an enable output, so the surrounding logic or a bench can model the tristate drivers.

Top module: `mux_bus_seq`

## Requirements
- R1: `ale` is high in T1 and only in T1. In T1, `ad_oe` is high and `ad_out` carries address bits 7..0.
- R2: In T2, T3, wait states and T4 of a write, `ad_oe` is high and `ad_out` carries the write byte. In those states of a read, `ad_oe` is low.
- R3: `addr_hi` carries address bits 15..8 of the current transfer from T1 through T4.
- R4: In T1, `ast` carries address bits 19..16 for a memory transfer (`req_io`=0) and 4'b0000 for an I/O transfer (`req_io`=1).
- R5: Outside T1, `ast` is {1'b0, S5, seg}. S5 is `int_en` as sampled on the previous clock edge. seg is the tag latched with the request: 2'b00 alternate data, 2'b01 stack, 2'b10 code or none, 2'b11 data.
- R6: `rd_n` is low in T2, T3 and every wait state of a read. It is high in every other state and for writes. It is never low while `ad_oe` is high.
- R7: After T3, a wait state follows each cycle in which `ready` is sampled low. T4 follows the first T3 or wait state in which `ready` is sampled high.
- R8: On a read, `rdata` takes the value of `ad_in` sampled on the edge that ends T3 or the last wait state. `rdata_valid` is high for exactly the T4 cycle.
- R9: `hold_ack` rises only after an idle cycle or a T4. It stays high while `hold_req` stays high and drops the cycle after `hold_req` is seen low. While it is high, `ad_oe` and `ctl_oe` are low.
- R10: `req_accept` is high, combinationally, when the sequencer is idle or in T4, `req` is high and `hold_req` is low. The next cycle is T1. Hold takes priority over a pending request. After reset the sequencer is idle, `rd_n`=1, `ale`=0, `hold_ack`=0 and `rdata_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_seg | input | 2 | Segment tag for status |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_accept | output | 1 | Request taken this cycle |
| int_en | input | 1 | Interrupt enable flag shown as S5 |
| ready | input | 1 | Device ready, sampled from T3 on |
| hold_req | input | 1 | External bus request |
| hold_ack | output | 1 | Bus released to external master |
| ad_out | output | 8 | Low address/data byte, driven side |
| ad_in | input | 8 | Low address/data byte, received side |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_hi | output | 8 | Address bits 15..8 |
| ast | output | 4 | Address 19..16 in T1, status afterwards |
| rd_n | output | 1 | Active-low read strobe |
| ale | output | 1 | Address latch enable |
| ctl_oe | output | 1 | Drive enable for addr_hi, ast and rd_n |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | rdata updated, high during T4 |

## Verification
The hardest situation to reach is a hold request that arrives in the middle of a transfer, together with a pending back-to-back request and a run of low ready cycles. The grant must then wait for T4, beat the queued request, and leave the strobe and captured data intact. The stimulus holds `req` high for long stretches and asserts `hold_req` in periodic bursts that are not aligned to the transfer length. It also shapes `ready` from a pseudo-random stream with a stretch of long stalls. As a result, hold rises in idle, in T4, and during T1 to wait states, and each case is compared to a behavioural model on every cycle.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_read,
  input  logic        req_io,
  input  logic [1:0]  req_seg,
  input  logic [19:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_accept,
  input  logic        int_en,
  input  logic        ready,
  input  logic        hold_req,
  output logic        hold_ack,
  output logic [7:0]  ad_out,
  input  logic [7:0]  ad_in,
  output logic        ad_oe,
  output logic [7:0]  addr_hi,
  output logic [3:0]  ast,
  output logic        rd_n,
  output logic        ale,
  output logic        ctl_oe,
  output logic [7:0]  rdata,
  output logic        rdata_valid
);
  localparam logic [2:0] S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_T3 = 3'd3,
                         S_TW = 3'd4, S_T4 = 3'd5, S_HOLD = 3'd6;

  logic [2:0]  state;
  logic [19:0] a_q;
  logic        rd_q, io_q, s5_q;
  logic [1:0]  seg_q;
  logic [7:0]  wd_q;

  wire between   = (state == S_IDLE) || (state == S_T4);
  wire data_ph   = (state == S_T2) || (state == S_T3) || (state == S_TW) || (state == S_T4);
  wire strobe_ph = (state == S_T2) || (state == S_T3) || (state == S_TW);
  wire done_wait = ((state == S_T3) || (state == S_TW)) && ready;

  assign req_accept = between && req && !hold_req;
  assign hold_ack   = (state == S_HOLD);
  assign ctl_oe     = !hold_ack;
  assign ale        = (state == S_T1);
  assign ad_oe      = ale || (data_ph && !rd_q);
  assign ad_out     = ale ? a_q[7:0] : wd_q;
  assign addr_hi    = a_q[15:8];
  assign ast        = ale ? (io_q ? 4'b0000 : a_q[19:16]) : {1'b0, s5_q, seg_q};
  assign rd_n       = !(rd_q && strobe_ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      a_q         <= '0;
      rd_q        <= 1'b0;
      io_q        <= 1'b0;
      seg_q       <= 2'b00;
      wd_q        <= '0;
      s5_q        <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      s5_q        <= int_en;
      rdata_valid <= done_wait && rd_q;
      if (done_wait && rd_q) rdata <= ad_in;
      if (req_accept) begin
        a_q   <= req_addr;
        rd_q  <= req_read;
        io_q  <= req_io;
        seg_q <= req_seg;
        wd_q  <= req_wdata;
      end
      case (state)
        S_IDLE, S_T4: state <= hold_req ? S_HOLD : (req ? S_T1 : S_IDLE);
        S_T1:         state <= S_T2;
        S_T2:         state <= S_T3;
        S_T3, S_TW:   state <= ready ? S_T4 : S_TW;
        S_HOLD:       state <= hold_req ? S_HOLD : S_IDLE;
        default:      state <= S_IDLE;
      endcase
    end
  end
endmodule

module mux_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       ale,
  input logic       ad_oe,
  input logic       rd_n,
  input logic       ready,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       ctl_oe,
  input logic       req_accept,
  input logic       rdata_valid
);
  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_ale_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);
  assert_strobe_no_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  assert_wait_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 3'd3 || st == 3'd4) && !ready) |=> (st == 3'd4));
  assert_valid_in_t4_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> (st == 3'd5));
  assert_hold_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!ad_oe && !ctl_oe));
  assert_hold_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && hold_req) |=> hold_ack);
  assert_hold_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack && !ale && (st != 3'd0) && (st != 3'd5)) |=> !hold_ack);
  assert_accept_t1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> ale);
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .ale(ale), .ad_oe(ad_oe), .rd_n(rd_n),
  .ready(ready), .hold_req(hold_req), .hold_ack(hold_ack), .ctl_oe(ctl_oe),
  .req_accept(req_accept), .rdata_valid(rdata_valid)
);

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_read = 1'b0, req_io = 1'b0;
  logic [1:0] req_seg = 2'b00;
  logic [19:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic int_en = 1'b0, ready = 1'b1, hold_req = 1'b0;
  logic [7:0] ad_in = '0;
  logic req_accept, hold_ack, ad_oe, rd_n, ale, ctl_oe, rdata_valid;
  logic [7:0] ad_out, addr_hi, rdata;
  logic [3:0] ast;

  always #2.5 clk = ~clk;

  mux_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_read(req_read), .req_io(req_io),
    .req_seg(req_seg), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_accept(req_accept), .int_en(int_en), .ready(ready), .hold_req(hold_req),
    .hold_ack(hold_ack), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .ast(ast), .rd_n(rd_n), .ale(ale), .ctl_oe(ctl_oe),
    .rdata(rdata), .rdata_valid(rdata_valid)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural model: phase 0 idle, 1..3 T1..T3, 4 wait, 5 T4, 6 hold
  int m_ph = 0;
  logic [19:0] m_addr = '0;
  logic m_rd = 0, m_io = 0, m_s5 = 0, m_valid = 0;
  logic [1:0] m_seg = 0;
  logic [7:0] m_wd = 0, m_rdata = 0;
  int n_wait = 0, n_hold = 0, n_rd = 0, n_wr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_addr = '0; m_rd = 0; m_io = 0; m_s5 = 0; m_valid = 0;
      m_seg = 0; m_wd = 0; m_rdata = 0;
    end else begin
      m_s5 = int_en;
      m_valid = 0;
      if ((m_ph == 3 || m_ph == 4) && ready && m_rd) begin
        m_rdata = m_addr[7:0] ^ 8'hA5;
        m_valid = 1;
      end
      case (m_ph)
        0, 5: begin
          if (hold_req) begin m_ph = 6; n_hold++; end
          else if (req) begin
            m_addr = req_addr; m_rd = req_read; m_io = req_io;
            m_seg = req_seg; m_wd = req_wdata; m_ph = 1;
            if (req_read) n_rd++; else n_wr++;
          end else m_ph = 0;
        end
        1: m_ph = 2;
        2: m_ph = 3;
        3, 4: begin
          if (ready) m_ph = 5; else begin m_ph = 4; n_wait++; end
        end
        6: if (!hold_req) m_ph = 0;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic e_oe;
    logic [3:0] e_ast;
    e_oe = (m_ph == 1) || (m_ph >= 2 && m_ph <= 5 && !m_rd);
    e_ast = (m_ph == 1) ? (m_io ? 4'b0000 : m_addr[19:16]) : {1'b0, m_s5, m_seg};
    chk(ale === (m_ph == 1), "R1 ale", ale, m_ph == 1);
    chk(ad_oe === e_oe, "R2 ad_oe", ad_oe, e_oe);
    if (m_ph == 1) chk(ad_out === m_addr[7:0], "R1 address low byte", ad_out, m_addr[7:0]);
    if (m_ph >= 2 && m_ph <= 5 && !m_rd) chk(ad_out === m_wd, "R2 write byte", ad_out, m_wd);
    if (m_ph >= 1 && m_ph <= 5) chk(addr_hi === m_addr[15:8], "R3 addr_hi", addr_hi, m_addr[15:8]);
    if (m_ph == 1) chk(ast === e_ast, "R4 address nibble", ast, e_ast);
    if (m_ph >= 2 && m_ph <= 5) chk(ast === e_ast, "R5 status nibble", ast, e_ast);
    chk(rd_n === !(m_rd && m_ph >= 2 && m_ph <= 4), "R6 rd_n", rd_n, !(m_rd && m_ph >= 2 && m_ph <= 4));
    chk((m_ph == 4) ? (!ale && ad_oe === !m_rd) : 1'b1, "R7 wait state drive", ad_oe, !m_rd);
    chk(rdata_valid === m_valid, "R8 rdata_valid", rdata_valid, m_valid);
    chk(rdata === m_rdata, "R8 rdata", rdata, m_rdata);
    chk(hold_ack === (m_ph == 6), "R9 hold_ack", hold_ack, m_ph == 6);
    chk(ctl_oe === (m_ph != 6), "R9 ctl_oe", ctl_oe, m_ph != 6);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lf;
    lf = 32'h1234_5678;
    repeat (3) begin
      @(negedge clk);
      chk(rd_n === 1'b1 && ale === 1'b0 && hold_ack === 1'b0 && rdata_valid === 1'b0,
          "R10 reset state", {rd_n, ale, hold_ack, rdata_valid}, 4'b1000);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 3600; c++) begin
      @(negedge clk);
      compare_all();
      lf = lf * 32'd1103515245 + 32'd12345;
      ad_in = (m_rd && m_ph >= 2 && m_ph <= 4) ? (m_addr[7:0] ^ 8'hA5) : 8'h00;
      if (c < 500) req = (c % 9 == 0) || (c % 9 == 1);
      else if (c < 1500) req = 1'b1;
      else req = lf[9];
      req_read = lf[12];
      req_io = lf[13] & lf[14];
      req_seg = lf[16:15];
      req_addr = lf[31:12];
      req_wdata = lf[27:20];
      int_en = lf[6];
      if (c < 250) ready = 1'b1;
      else if (c >= 1200 && c < 1400) ready = (c % 6 == 0);
      else ready = (lf[19:18] != 2'b00);
      hold_req = (c >= 1500) && ((c / 11) % 4 == 0);
      if (c >= 3000) hold_req = 1'b0;
      #1;
      chk(req_accept === ((m_ph == 0 || m_ph == 5) && req && !hold_req), "R10 req_accept",
          req_accept, (m_ph == 0 || m_ph == 5) && req && !hold_req);
    end
    chk(n_wait > 20, "R7 wait states seen", n_wait, 21);
    chk(n_hold > 20, "R9 hold grants seen", n_hold, 21);
    chk(n_rd > 50 && n_wr > 50, "R8 reads and writes seen", n_rd, n_wr);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule